// File: doc/BRIEF.md
# Flash Self-Programming Command Sequencer

This block takes self-programming commands from the CPU side and carries them out on a flash-array model. The array holds 128 pages of 32 sixteen-bit words. Software first writes a 5-bit command word. It then issues a strobe within a short window, and the strobe carries a 16-bit pointer and a data word. The command sets the action:

- load one word into a one-page temporary buffer;
- erase a page;
- program a page from the buffer;
- program the lock bits;
- re-open the lower region for reads.

Erase, page program and lock programming take a number of cycles set by `prog_cycles_i`. The flash is divided into two regions. The lower 96 pages form a region that stays readable while other pages are being programmed. The upper 32 pages are always readable. After an erase or program on a lower page, the lower region stays closed to reads until software sends the re-open command. Strobes are refused while an EEPROM write is pending.

Two resets are used. `rst_ni` clears only the command and read-port state, so an operation already in flight still runs to completion. `por_ni` returns everything to its power-up state: the array, the buffer, the lock bits and the engine.

Top module: `flash_selfprog_seq`

## Requirements
- R1: The pointer is decoded as follows. Bits 12:6 select the page, bits 5:1 select the buffer word, and bits 15:13 are ignored. A strobe with bit 0 set is refused: no operation runs, and the armed command is dropped.
- R2: The command word has the enable bit at bit 0, erase at bit 1, program at bit 2, lock at bit 3 and re-open at bit 4. Only five values act: 5'b00001 (load word), 5'b00011 (erase), 5'b00101 (program), 5'b01001 (lock) and 5'b10001 (re-open). A strobe with any other armed value does nothing.
- R3: A command written at clock edge T is taken only by a strobe at edges T+1 to T+4. If no strobe arrives by T+4, `busy_o` drops after T+4 and a later strobe has no effect.
- R4: `busy_o` is high from the accepted command write until the command or operation finishes. A command write while `busy_o` is high is ignored.
- R5: An erase or program started at edge S ends at edge S+N, where N is `prog_cycles_i` (0 counts as 1). An erase sets all 32 words of the page to 16'hFFFF.
- R6: A program copies the buffer into the page and then sets every buffer word to 16'hFFFF. A program strobe with a nonzero word field is refused.
- R7: A lock command ANDs `wdata_i[5:0]` into `lock_o` at the end of the operation, so lock bits can only go from 1 to 0.
- R8: Erase or program of a page below 96 (word address below 12'hC00) sets `rww_busy_o`. The flag stays set until an accepted re-open command clears it. While it is set, a read of a word below 12'hC00 returns `rd_ok_o`=0 and `rd_data_o`=0.
- R9: A read of a word at or above 12'hC00 always succeeds. Operations on pages 96 and above do not set `rww_busy_o`.
- R10: A strobe while `ee_busy_i` is high starts nothing and drops the armed command.
- R11: Asserting `rst_ni` does not stop an operation in flight: it completes and its result is kept. `por_ni` sets the array and buffer to all ones and `lock_o` to 6'h3F, and clears both busy flags.
- R12: A read requested at edge E presents `rd_ok_o` and `rd_data_o` after edge E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async reset of command and read state |
| por_ni | input | 1 | Active-low async power-on reset of everything |
| cmd_wr_i | input | 1 | Command word write |
| cmd_i | input | 5 | Command word |
| spm_i | input | 1 | Command strobe |
| ptr_i | input | 16 | Address pointer |
| wdata_i | input | 16 | Buffer word or lock data |
| ee_busy_i | input | 1 | EEPROM write pending |
| prog_cycles_i | input | 16 | Operation length in cycles |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 12 | Read word address |
| rd_data_o | output | 16 | Read data |
| rd_ok_o | output | 1 | Read was allowed |
| busy_o | output | 1 | Command armed or operation running |
| rww_busy_o | output | 1 | Lower region closed to reads |
| lock_o | output | 6 | Lock bits |

## Verification
The checks assume the following about the inputs:

- `prog_cycles_i` is held constant while an operation runs.
- A read is never requested on the same edge that an operation commits to the page being read.
- Strobes come only from the CPU side, one per armed command.

The stimulus drives every input on the falling edge. It lets each operation finish before reading the page it touched. The random phase picks page numbers, words and pointer bits 15:13 freely, but keeps the operation length fixed.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int CMD_W  = 5;
  localparam int DATA_W = 16;
  localparam int PTR_W  = 16;

  localparam logic [CMD_W-1:0] CMD_FILL  = 5'b00001;
  localparam logic [CMD_W-1:0] CMD_ERASE = 5'b00011;
  localparam logic [CMD_W-1:0] CMD_PROG  = 5'b00101;
  localparam logic [CMD_W-1:0] CMD_LOCK  = 5'b01001;
  localparam logic [CMD_W-1:0] CMD_REEN  = 5'b10001;

  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_ERASE, OP_PROG, OP_LOCK} op_e;
endpackage

// File: rtl/fsp_cmd_ctrl.sv
module fsp_cmd_ctrl
  import fsp_pkg::*;
#(
  parameter int PAGE_WORDS = 32,
  parameter int NUM_PAGES  = 128,
  parameter int ARM_WINDOW = 4,
  localparam int WORD_W = $clog2(PAGE_WORDS),
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int ADDR_W = PAGE_W + WORD_W,
  localparam int WIN_W  = $clog2(ARM_WINDOW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              spm_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              ee_busy_i,
  input  logic              op_active_i,
  output logic              armed_o,
  output logic              fill_o,
  output logic              reen_o,
  output logic              start_o,
  output op_e               op_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [WORD_W-1:0] word_o
);
  logic [CMD_W-1:0] cmd_q;
  logic [WIN_W-1:0] win_q;
  logic             take;

  assign armed_o = cmd_q[0];
  assign word_o  = ptr_i[WORD_W:1];
  assign page_o  = ptr_i[ADDR_W:WORD_W+1];
  assign take    = spm_i & armed_o & ~ee_busy_i & ~ptr_i[0];

  always_comb begin
    fill_o  = 1'b0;
    reen_o  = 1'b0;
    start_o = 1'b0;
    op_o    = OP_NONE;
    if (take) begin
      unique case (cmd_q)
        CMD_FILL:  fill_o = 1'b1;
        CMD_ERASE: begin start_o = 1'b1; op_o = OP_ERASE; end
        CMD_PROG:  if (word_o == '0) begin start_o = 1'b1; op_o = OP_PROG; end
        CMD_LOCK:  begin start_o = 1'b1; op_o = OP_LOCK; end
        CMD_REEN:  reen_o = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      win_q <= '0;
    end else if (cmd_wr_i && !armed_o && !op_active_i) begin
      cmd_q <= cmd_i[0] ? cmd_i : '0;
      win_q <= cmd_i[0] ? WIN_W'(ARM_WINDOW) : '0;
    end else if (armed_o) begin
      // any strobe consumes the armed command, accepted or not
      if (spm_i || win_q == WIN_W'(1)) begin
        cmd_q <= '0;
        win_q <= '0;
      end else begin
        win_q <= win_q - WIN_W'(1);
      end
    end
  end
endmodule

// File: rtl/fsp_page_buf.sv
module fsp_page_buf #(
  parameter int PAGE_WORDS = 32,
  parameter int DATA_W     = 16,
  localparam int WORD_W = $clog2(PAGE_WORDS)
) (
  input  logic                                  clk_i,
  input  logic                                  por_ni,
  input  logic                                  fill_i,
  input  logic [WORD_W-1:0]                     word_i,
  input  logic [DATA_W-1:0]                     data_i,
  input  logic                                  clr_i,
  output logic [PAGE_WORDS-1:0][DATA_W-1:0]     pbuf_o
);
  for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)                                      pbuf_o[w] <= '1;
      else if (clr_i)                                   pbuf_o[w] <= '1;
      else if (fill_i && word_i == WORD_W'(w))          pbuf_o[w] <= data_i;
    end
  end
endmodule

// File: rtl/fsp_op_engine.sv
module fsp_op_engine
  import fsp_pkg::*;
#(
  parameter int NUM_PAGES = 128,
  parameter int RWW_PAGES = 96,
  parameter int CNT_W     = 16,
  parameter int LOCK_W    = 6,
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              reen_i,
  input  logic [LOCK_W-1:0] lock_data_i,
  input  logic [CNT_W-1:0]  prog_cycles_i,
  output logic              active_o,
  output logic              rww_busy_o,
  output logic [LOCK_W-1:0] lock_o,
  output logic              commit_o,
  output op_e               commit_op_o,
  output logic [PAGE_W-1:0] commit_page_o
);
  localparam logic [PAGE_W-1:0] RWW_LIMIT = PAGE_W'(RWW_PAGES);

  logic [CNT_W-1:0]  cnt_q;
  logic [LOCK_W-1:0] lock_data_q;

  assign commit_o = active_o & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      active_o      <= 1'b0;
      cnt_q         <= '0;
      commit_op_o   <= OP_NONE;
      commit_page_o <= '0;
      lock_data_q   <= '1;
      rww_busy_o    <= 1'b0;
      lock_o        <= '1;
    end else begin
      if (reen_i) rww_busy_o <= 1'b0;
      if (start_i) begin
        active_o      <= 1'b1;
        cnt_q         <= (prog_cycles_i == '0) ? CNT_W'(1) : prog_cycles_i;
        commit_op_o   <= op_i;
        commit_page_o <= page_i;
        lock_data_q   <= lock_data_i;
        if (op_i != OP_LOCK && page_i < RWW_LIMIT) rww_busy_o <= 1'b1;
      end else if (active_o) begin
        if (commit_o) begin
          active_o <= 1'b0;
          if (commit_op_o == OP_LOCK) lock_o <= lock_o & lock_data_q;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fsp_flash_array.sv
module fsp_flash_array
  import fsp_pkg::*;
#(
  parameter int PAGE_WORDS = 32,
  parameter int NUM_PAGES  = 128,
  parameter int RWW_PAGES  = 96,
  localparam int WORD_W    = $clog2(PAGE_WORDS),
  localparam int PAGE_W    = $clog2(NUM_PAGES),
  localparam int ADDR_W    = PAGE_W + WORD_W,
  localparam int NUM_WORDS = NUM_PAGES * PAGE_WORDS
) (
  input  logic                              clk_i,
  input  logic                              por_ni,
  input  logic                              rst_ni,
  input  logic                              commit_i,
  input  op_e                               commit_op_i,
  input  logic [PAGE_W-1:0]                 commit_page_i,
  input  logic [PAGE_WORDS-1:0][DATA_W-1:0] pbuf_i,
  input  logic                              rww_busy_i,
  input  logic                              rd_en_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output logic [DATA_W-1:0]                 rd_data_o,
  output logic                              rd_ok_o
);
  localparam logic [ADDR_W-1:0] RWW_ADDR_LIMIT = ADDR_W'(RWW_PAGES * PAGE_WORDS);

  logic [DATA_W-1:0] mem [NUM_WORDS];
  logic              rd_allow;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '1;
    end else if (commit_i && commit_op_i != OP_LOCK && commit_op_i != OP_NONE) begin
      for (int w = 0; w < PAGE_WORDS; w++)
        mem[{commit_page_i, WORD_W'(w)}] <= (commit_op_i == OP_ERASE) ? '1 : pbuf_i[w];
    end
  end

  assign rd_allow = rd_en_i & ~(rww_busy_i & (rd_addr_i < RWW_ADDR_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ok_o   <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_ok_o   <= rd_allow;
      rd_data_o <= rd_allow ? mem[rd_addr_i] : '0;
    end
  end
endmodule

// File: rtl/flash_selfprog_seq.sv
module flash_selfprog_seq
  import fsp_pkg::*;
#(
  parameter int PAGE_WORDS = 32,
  parameter int NUM_PAGES  = 128,
  parameter int RWW_PAGES  = 96,
  parameter int CNT_W      = 16,
  parameter int LOCK_W     = 6,
  parameter int ARM_WINDOW = 4,
  localparam int WORD_W = $clog2(PAGE_WORDS),
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int ADDR_W = PAGE_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              cmd_wr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              spm_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ee_busy_i,
  input  logic [CNT_W-1:0]  prog_cycles_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_ok_o,
  output logic              busy_o,
  output logic              rww_busy_o,
  output logic [LOCK_W-1:0] lock_o
);
  logic              armed, fill, reen, start, op_active, commit;
  op_e               op, commit_op;
  logic [PAGE_W-1:0] page, commit_page;
  logic [WORD_W-1:0] word;
  logic [PAGE_WORDS-1:0][DATA_W-1:0] pbuf;

  assign busy_o = armed | op_active;

  fsp_cmd_ctrl #(
    .PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES), .ARM_WINDOW(ARM_WINDOW)
  ) u_cmd (
    .clk_i, .rst_ni, .cmd_wr_i, .cmd_i, .spm_i, .ptr_i, .ee_busy_i,
    .op_active_i(op_active), .armed_o(armed), .fill_o(fill), .reen_o(reen),
    .start_o(start), .op_o(op), .page_o(page), .word_o(word)
  );

  fsp_page_buf #(.PAGE_WORDS(PAGE_WORDS), .DATA_W(DATA_W)) u_buf (
    .clk_i, .por_ni, .fill_i(fill), .word_i(word), .data_i(wdata_i),
    .clr_i(commit & (commit_op == OP_PROG)), .pbuf_o(pbuf)
  );

  fsp_op_engine #(
    .NUM_PAGES(NUM_PAGES), .RWW_PAGES(RWW_PAGES), .CNT_W(CNT_W), .LOCK_W(LOCK_W)
  ) u_eng (
    .clk_i, .por_ni, .start_i(start), .op_i(op), .page_i(page), .reen_i(reen),
    .lock_data_i(wdata_i[LOCK_W-1:0]), .prog_cycles_i, .active_o(op_active),
    .rww_busy_o, .lock_o, .commit_o(commit), .commit_op_o(commit_op),
    .commit_page_o(commit_page)
  );

  fsp_flash_array #(
    .PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES), .RWW_PAGES(RWW_PAGES)
  ) u_arr (
    .clk_i, .por_ni, .rst_ni, .commit_i(commit), .commit_op_i(commit_op),
    .commit_page_i(commit_page), .pbuf_i(pbuf), .rww_busy_i(rww_busy_o),
    .rd_en_i, .rd_addr_i, .rd_data_o, .rd_ok_o
  );
endmodule

// File: rtl/fsp_seq_chk.sv
module fsp_seq_chk #(
  parameter int ADDR_W    = 12,
  parameter int LOCK_W    = 6,
  parameter int RWW_WORDS = 3072
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_ni,
  input logic              spm_i,
  input logic              ee_busy_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              rd_ok_o,
  input logic              busy_o,
  input logic              rww_busy_o,
  input logic [LOCK_W-1:0] lock_o,
  input logic              op_active
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(RWW_WORDS);

  AST_RWW_READ_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    rww_busy_o && rd_en_i && rd_addr_i < LIMIT |=> !rd_ok_o); // R8

  AST_NRWW_READ_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    rd_en_i && rd_addr_i >= LIMIT |=> rd_ok_o); // R9

  AST_NO_START_DURING_EE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(op_active) |-> $past(!ee_busy_i)); // R10

  AST_START_NEEDS_ARMED_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(op_active) |-> $past(spm_i && busy_o)); // R3

  AST_REGION_RELEASE_BY_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $fell(rww_busy_o) |-> $past(spm_i && !op_active)); // R8

  AST_LOCK_ONLY_CLEARS: assert property (@(posedge clk_i) disable iff (!por_ni)
    (lock_o & ~$past(lock_o)) == '0); // R7
endmodule

bind flash_selfprog_seq fsp_seq_chk #(
  .ADDR_W(ADDR_W), .LOCK_W(LOCK_W), .RWW_WORDS(RWW_PAGES * PAGE_WORDS)
) u_chk (
  .clk_i, .rst_ni, .por_ni, .spm_i, .ee_busy_i, .rd_en_i, .rd_addr_i,
  .rd_ok_o, .busy_o, .rww_busy_o, .lock_o, .op_active(op_active)
);

// File: tb/tb_flash_selfprog_seq.sv
module tb_flash_selfprog_seq;
  import fsp_pkg::*;

  logic        clk = 1'b0, rst_ni = 1'b0, por_ni = 1'b0;
  logic        cmd_wr = 1'b0, spm = 1'b0, ee_busy = 1'b0, rd_en = 1'b0;
  logic [4:0]  cmd = '0;
  logic [15:0] ptr = '0, wdata = '0, prog = 16'd20;
  logic [11:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_ok, busy, rww_busy;
  logic [5:0]  lock;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_mem [4096];
  logic [15:0] m_buf [32];
  logic [5:0]  m_lock;
  logic        m_rww;

  always #2 clk = ~clk;

  flash_selfprog_seq dut (
    .clk_i(clk), .rst_ni, .por_ni, .cmd_wr_i(cmd_wr), .cmd_i(cmd), .spm_i(spm),
    .ptr_i(ptr), .wdata_i(wdata), .ee_busy_i(ee_busy), .prog_cycles_i(prog),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_ok_o(rd_ok),
    .busy_o(busy), .rww_busy_o(rww_busy), .lock_o(lock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [15:0] mk_ptr(int page, int word, int hi);
    return {hi[2:0], page[6:0], word[4:0], 1'b0};
  endfunction

  task automatic model_por();
    for (int i = 0; i < 4096; i++) m_mem[i] = '1;
    for (int w = 0; w < 32; w++) m_buf[w] = '1;
    m_lock = '1;
    m_rww  = 1'b0;
  endtask

  // cmd write, then strobe on the dly-th edge after it
  task automatic issue(input logic [4:0] c, input logic [15:0] p, input logic [15:0] d, input int dly);
    @(negedge clk); cmd_wr = 1'b1; cmd = c;
    @(negedge clk); cmd_wr = 1'b0;
    repeat (dly - 1) @(negedge clk);
    spm = 1'b1; ptr = p; wdata = d;
    @(negedge clk); spm = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic chk_read(input int addr, input string req);
    logic exp_ok;
    @(negedge clk); rd_en = 1'b1; rd_addr = addr[11:0];
    @(negedge clk); rd_en = 1'b0;
    exp_ok = !(m_rww && addr < 12'hC00);
    chk({req, " rd_ok"}, rd_ok, exp_ok);
    chk({req, " rd_data"}, rd_data, exp_ok ? m_mem[addr] : 16'h0);
  endtask

  task automatic do_fill(int word, logic [15:0] d, int hi);
    issue(CMD_FILL, mk_ptr(0, word, hi), d, 1);
    m_buf[word] = d;
  endtask

  task automatic do_prog(int page, string req);
    int c;
    issue(CMD_PROG, mk_ptr(page, 0, 0), 16'h0, 1);
    wait_idle(c);
    chk({req, " length"}, c, (prog == 0) ? 1 : prog);
    for (int w = 0; w < 32; w++) begin m_mem[page*32+w] = m_buf[w]; m_buf[w] = '1; end
    if (page < 96) m_rww = 1'b1;
  endtask

  task automatic do_erase(int page, string req);
    int c;
    issue(CMD_ERASE, mk_ptr(page, 0, 0), 16'h0, 1);
    wait_idle(c);
    chk({req, " length"}, c, (prog == 0) ? 1 : prog);
    for (int w = 0; w < 32; w++) m_mem[page*32+w] = '1;
    if (page < 96) m_rww = 1'b1;
  endtask

  task automatic do_reen();
    issue(CMD_REEN, 16'h0, 16'h0, 1);
    m_rww = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    int c;
    void'($urandom(32'd20240611));
    model_por();
    repeat (3) @(negedge clk);
    por_ni = 1'b1; rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy after reset", busy, 0);
    chk("R11 rww after reset", rww_busy, 0);
    chk("R11 lock after reset", lock, 6'h3F);
    chk_read(0, "R12 erased read");

    // R6/R1/R8: fill with random upper pointer bits, program a lower page
    for (int w = 0; w < 32; w++) do_fill(w, 16'(w * 16'h0101 + 16'h1000), $urandom_range(7));
    do_prog(2, "R5 program");
    chk("R8 rww set", rww_busy, 1);
    chk_read(2*32 + 3, "R8 blocked read");
    chk_read(12'hC05, "R9 upper read while closed");
    do_reen();
    chk("R8 rww cleared", rww_busy, 0);
    for (int w = 0; w < 32; w++) chk_read(2*32 + w, "R6 page content");

    // R6 buffer cleared after program
    for (int w = 0; w < 32; w++) do_fill(w, 16'hA5A5, 0);
    do_prog(5, "R5 program");
    do_fill(0, 16'h1234, 0);
    do_prog(5, "R5 program");
    do_reen();
    chk_read(5*32 + 0, "R6 new word");
    chk_read(5*32 + 17, "R6 buffer cleared");

    // R5 erase, R9 upper region program does not close lower region
    do_erase(2, "R5 erase");
    do_reen();
    chk_read(2*32 + 9, "R5 erased word");
    do_fill(4, 16'hBEEF, 0);
    do_prog(100, "R9 program upper");
    chk("R9 rww stays clear", rww_busy, 0);
    chk_read(100*32 + 4, "R9 upper data");

    // R3 window: strobe at 4th edge taken, at 5th ignored
    do_fill(6, 16'h0F0F, 0);  // reference
    issue(CMD_FILL, mk_ptr(0, 7, 0), 16'h7777, 4);
    m_buf[7] = 16'h7777;
    issue(CMD_FILL, mk_ptr(0, 8, 0), 16'h8888, 5);
    chk("R3 busy dropped after window", busy, 0);
    do_prog(101, "R3 program");
    chk_read(101*32 + 7, "R3 fourth-edge strobe");
    chk_read(101*32 + 8, "R3 late strobe ignored");

    // R1 pointer bit 0 set refuses
    issue(CMD_ERASE, mk_ptr(101, 0, 0) | 16'h1, 16'h0, 1);
    chk("R1 no op on odd pointer", busy, 0);
    chk_read(101*32 + 7, "R1 page untouched");

    // R6 program with nonzero word field refused
    do_fill(1, 16'h5555, 0);
    issue(CMD_PROG, mk_ptr(102, 3, 0), 16'h0, 1);
    chk("R6 refused program", busy, 0);
    chk_read(102*32 + 1, "R6 page untouched");

    // R2 invalid encoding
    issue(5'b00111, mk_ptr(101, 0, 0), 16'h0, 1);
    chk("R2 invalid cmd no op", busy, 0);
    chk_read(101*32 + 7, "R2 page untouched");

    // R10 EEPROM pending
    ee_busy = 1'b1;
    issue(CMD_ERASE, mk_ptr(101, 0, 0), 16'h0, 1);
    ee_busy = 1'b0;
    chk("R10 no op while ee busy", busy, 0);
    chk_read(101*32 + 7, "R10 page untouched");

    // R7 lock bits
    issue(CMD_LOCK, 16'h0, 16'hFF3A, 1);
    wait_idle(c);
    m_lock = m_lock & 6'h3A;
    chk("R7 lock cleared", lock, m_lock);
    chk("R7 lock no rww", rww_busy, 0);
    issue(CMD_LOCK, 16'h0, 16'hFFFF, 1);
    wait_idle(c);
    chk("R7 lock cannot set", lock, m_lock);

    // R4 busy and command write ignored while busy
    issue(CMD_ERASE, mk_ptr(103, 0, 0), 16'h0, 1);
    chk("R4 busy during op", busy, 1);
    issue(CMD_FILL, mk_ptr(0, 9, 0), 16'h9999, 1);
    wait_idle(c);
    for (int w = 0; w < 32; w++) m_mem[103*32+w] = '1;
    do_prog(104, "R4 program");
    chk_read(104*32 + 9, "R4 ignored fill");
    chk_read(104*32 + 1, "R4 earlier fill kept");

    // R5 zero length counts as one
    prog = 16'd0;
    do_erase(104, "R5 zero length");
    prog = 16'd20;

    // R11 rst_ni mid-operation
    do_fill(2, 16'hC0DE, 0);
    issue(CMD_PROG, mk_ptr(110, 0, 0), 16'h0, 1);
    repeat (4) @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 op continues in reset", busy, 1);
    rst_ni = 1'b1;
    wait_idle(c);
    for (int w = 0; w < 32; w++) begin m_mem[110*32+w] = m_buf[w]; m_buf[w] = '1; end
    chk_read(110*32 + 2, "R11 completed write");

    // random phase
    prog = 16'd8;
    for (int it = 0; it < 30; it++) begin
      int pg, k;
      pg = $urandom_range(127);
      k  = $urandom_range(1, 6);
      if ($urandom_range(3) == 0) do_erase(pg, "R5 random erase");
      else begin
        for (int j = 0; j < k; j++) do_fill($urandom_range(31), 16'($urandom), $urandom_range(7));
        do_prog(pg, "R6 random program");
      end
      if ($urandom_range(1) == 1) chk_read(pg*32 + $urandom_range(31), "R8 random read");
      if (m_rww) do_reen();
      for (int j = 0; j < 3; j++) chk_read(pg*32 + $urandom_range(31), "R6 random read");
    end

    // R11 power-on reset
    @(negedge clk); por_ni = 1'b0; rst_ni = 1'b0;
    @(negedge clk); por_ni = 1'b1; rst_ni = 1'b1;
    model_por();
    chk("R11 lock after por", lock, 6'h3F);
    chk_read(2*32 + 3, "R11 array after por");
    chk_read(110*32 + 2, "R11 array after por");
    summary();
  end
endmodule